// File: doc/BRIEF.md
# Trigger-Latency Sample Buffer and Event Builder

This block sits behind a bank of ADC channels that are sampled once per clock, at six clocks per beam crossing. Every clock it stores one sample of each channel in a circular memory. The samples therefore remain available for a programmable number of clocks after they arrive. When a level-1 accept arrives, the block copies a window of twelve consecutive samples per channel from that memory into a small multi-event queue. Twelve samples span two beam crossings. The copied window ends a programmed latency before the trigger.

Readout of queued events runs independently of capture, so triggers keep being accepted while an earlier event is still leaving the block. Each event leaves as a stream of 32-bit words, one per clock, toward a data collection link. The stream is a header carrying an event number and a beam-crossing number, then every channel's window in turn, then a trailer carrying the sample word count. A trigger is dropped when the queue is full or a capture is still in progress. Dropped triggers are tallied in a saturating counter.

Top module: `l1f_event_builder`

## Requirements
- R1: After reset, out_valid is 0, out_word is 0, queue_full is 0 and overflow_count is 0.
- R2: If m is the sample presented in the clock where a trigger is accepted and LAT is the effective latency, each channel's captured window is samples m-LAT-WIN through m-LAT-1, oldest first.
- R3: A latency_cfg value above DEPTH-WIN-1 is treated as DEPTH-WIN-1 (51 with defaults).
- R4: An event is sent on consecutive clocks with out_valid high: one header, then NCH*WIN sample words with channel 0 first and, within a channel, time index 0 first, then one trailer. While out_valid is low, out_word is zero.
- R5: Word encodings. A header has bits [31:30]=01, the event number in [19:8] and the crossing number in [7:0]. A sample word has [31:30]=00, the channel in [21:16], the time index in [15:12] and the sample in [11:0]. A trailer has [31:30]=11 and NCH*WIN in [15:0]. All other bits are zero.
- R6: The event number is 0 for the first accepted trigger after reset and rises by one, modulo 4096, for each accepted trigger. Dropped triggers consume no number. The crossing number is floor(E/6) mod 256, where E is the number of clock edges since reset release that precede the accepting edge.
- R7: With nothing else queued, the header appears on the clock edge WIN+1 clocks after the accepting edge.
- R8: The queue holds NQ events. queue_full is high while NQ events are held, counting an event from the accepting edge until the edge that sends its trailer. A trigger that arrives while the queue is full is dropped.
- R9: A trigger that arrives while a capture is in progress, that is within WIN clocks after an accepted trigger, is dropped.
- R10: Each clock with a dropped trigger adds one to overflow_count, which holds at 255 once it gets there.
- R11: Events are sent in the order they were accepted, and triggers are accepted while an earlier event is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per channel per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_samples | input | NCH*12 | One 12-bit sample per channel; channel c in bits [12c+11:12c] |
| l1_accept | input | 1 | Level-1 accept; each high clock is one trigger |
| latency_cfg | input | log2(DEPTH) | Trigger latency in sample clocks |
| out_valid | output | 1 | out_word carries an event word |
| out_word | output | 32 | Header, sample or trailer word |
| queue_full | output | 1 | NQ events are held |
| overflow_count | output | 8 | Saturating count of dropped triggers |

## Verification
The in-module assertions rely on two conditions. First, the formatter only releases a slot the queue actually holds. Second, once a header starts, the event store returns whatever the capture wrote. The window contents are only meaningful once the ring has been filled after reset, so the stimulus drives a changing sample pattern every clock and waits more than DEPTH clocks before the first trigger. The stimulus changes l1_accept and latency_cfg only just after a falling edge. The latency setting is held constant from before a trigger until its event has been sent, because the assertions and expected windows assume a steady latency across a capture.

// File: rtl/l1f_pkg.sv
package l1f_pkg;
  localparam int ADC_W  = 12;
  localparam int WORD_W = 32;
  localparam int EVN_W  = 12;
  localparam int XING_W = 8;
  localparam int CHF_W  = 6;
  localparam int TIX_W  = 4;

  localparam logic [1:0] KIND_SMP = 2'b00;
  localparam logic [1:0] KIND_HDR = 2'b01;
  localparam logic [1:0] KIND_TRL = 2'b11;

  function automatic logic [WORD_W-1:0] make_hdr(input logic [EVN_W-1:0] evn,
                                                 input logic [XING_W-1:0] xing);
    return {KIND_HDR, 10'b0, evn, xing};
  endfunction

  function automatic logic [WORD_W-1:0] make_smp(input logic [CHF_W-1:0] ch,
                                                 input logic [TIX_W-1:0] tix,
                                                 input logic [ADC_W-1:0] val);
    return {KIND_SMP, 8'b0, ch, tix, val};
  endfunction

  function automatic logic [WORD_W-1:0] make_trl(input logic [15:0] cnt);
    return {KIND_TRL, 14'b0, cnt};
  endfunction

  function automatic int unsigned clamp_lat(input int unsigned cfg, input int unsigned maxv);
    return (cfg > maxv) ? maxv : cfg;
  endfunction
endpackage

// File: rtl/l1f_delay_ring.sv
module l1f_delay_ring #(
  parameter int NCH   = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = NCH * l1f_pkg::ADC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_ptr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] ring_mem [DEPTH];
  logic [AW-1:0] wr_ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr_q <= '0;
    else        wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    ring_mem[wr_ptr_q] <= wr_data;
  end

  assign wr_ptr  = wr_ptr_q;
  assign rd_data = ring_mem[rd_addr];
endmodule

// File: rtl/l1f_capture_ctrl.sv
module l1f_capture_ctrl #(
  parameter int NCH   = 8,
  parameter int WIN   = 12,
  parameter int DEPTH = 64,
  parameter int NQ    = 4,
  parameter int XDIV  = 6,
  parameter int OVF_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int KW     = $clog2(WIN),
  localparam int SLOT_W = $clog2(NQ),
  localparam int OCC_W  = $clog2(NQ + 1),
  localparam int XW     = $clog2(XDIV),
  localparam int MAXLAT = DEPTH - WIN - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      l1_accept,
  input  logic [AW-1:0]             latency_cfg,
  input  logic [AW-1:0]             wr_ptr,
  input  logic                      slot_release,
  output logic                      cap_we,
  output logic [SLOT_W-1:0]         cap_slot,
  output logic [KW-1:0]             cap_k,
  output logic [AW-1:0]             ring_rd_addr,
  output logic [SLOT_W-1:0]         rd_slot,
  output logic                      ev_ready,
  output logic [l1f_pkg::EVN_W-1:0]  hdr_evn,
  output logic [l1f_pkg::XING_W-1:0] hdr_xing,
  output logic                      queue_full,
  output logic [OVF_W-1:0]          overflow_count
);
  import l1f_pkg::*;

  logic [XW-1:0]     phase_q;
  logic [XING_W-1:0] xing_q;
  logic [EVN_W-1:0]  evn_q;
  logic [OCC_W-1:0]  occ_q;
  logic [SLOT_W-1:0] wslot_q, rslot_q, cslot_q;
  logic              cap_active_q;
  logic [KW-1:0]     cap_k_q;
  logic [AW-1:0]     base_q;
  logic [OVF_W-1:0]  ovf_q;
  logic [EVN_W-1:0]  meta_evn  [NQ];
  logic [XING_W-1:0] meta_xing [NQ];

  // named internal events
  logic          accept_evt, drop_evt, cap_last;
  logic [AW-1:0] lat_eff, win_base;

  assign lat_eff    = AW'(clamp_lat(32'(latency_cfg), MAXLAT));
  assign win_base   = wr_ptr - lat_eff - AW'(WIN);
  assign accept_evt = l1_accept && !cap_active_q && (occ_q < OCC_W'(NQ));
  assign drop_evt   = l1_accept && !accept_evt;
  assign cap_last   = cap_active_q && (cap_k_q == KW'(WIN - 1));

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(NQ - 1)) ? '0 : s + 1'b1;
  endfunction

  // crossing counter: one count per XDIV sample clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      xing_q  <= '0;
    end else if (phase_q == XW'(XDIV - 1)) begin
      phase_q <= '0;
      xing_q  <= xing_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // capture sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_active_q <= 1'b0;
      cap_k_q      <= '0;
      base_q       <= '0;
      cslot_q      <= '0;
    end else if (accept_evt) begin
      cap_active_q <= 1'b1;
      cap_k_q      <= '0;
      base_q       <= win_base;
      cslot_q      <= wslot_q;
    end else if (cap_last) begin
      cap_active_q <= 1'b0;
      cap_k_q      <= '0;
    end else if (cap_active_q) begin
      cap_k_q <= cap_k_q + 1'b1;
    end
  end

  // queue bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      wslot_q <= '0;
      rslot_q <= '0;
      evn_q   <= '0;
      ovf_q   <= '0;
    end else begin
      case ({accept_evt, slot_release})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
      if (accept_evt) begin
        wslot_q <= next_slot(wslot_q);
        evn_q   <= evn_q + 1'b1;
      end
      if (slot_release) rslot_q <= next_slot(rslot_q);
      if (drop_evt && (ovf_q != '1)) ovf_q <= ovf_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_evt) begin
      meta_evn[wslot_q]  <= evn_q;
      meta_xing[wslot_q] <= xing_q;
    end
  end

  assign cap_we         = cap_active_q;
  assign cap_slot       = cslot_q;
  assign cap_k          = cap_k_q;
  assign ring_rd_addr   = base_q + AW'(cap_k_q);
  assign rd_slot        = rslot_q;
  assign ev_ready       = occ_q > OCC_W'(cap_active_q);
  assign hdr_evn        = meta_evn[rslot_q];
  assign hdr_xing       = meta_xing[rslot_q];
  assign queue_full     = (occ_q == OCC_W'(NQ));
  assign overflow_count = ovf_q;

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(NQ));
  assert_release_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_release |-> (occ_q != '0) && !(cap_active_q && occ_q == OCC_W'(1)));
  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_active_q && !cap_last |=> $stable(evn_q) || cap_active_q);
  assert_drop_counted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && (ovf_q != '1) |=> ovf_q == $past(ovf_q) + 1'b1);
  assert_ovf_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q == '1) |=> (ovf_q == '1));
endmodule

// File: rtl/l1f_event_store.sv
module l1f_event_store #(
  parameter int NCH = 8,
  parameter int WIN = 12,
  parameter int NQ  = 4,
  localparam int KW     = $clog2(WIN),
  localparam int CW     = $clog2(NCH),
  localparam int SLOT_W = $clog2(NQ),
  localparam int DW     = NCH * l1f_pkg::ADC_W
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [SLOT_W-1:0]          wslot,
  input  logic [KW-1:0]              wk,
  input  logic [DW-1:0]              wdata,
  input  logic [SLOT_W-1:0]          rslot,
  input  logic [CW-1:0]              rch,
  input  logic [KW-1:0]              rk,
  output logic [l1f_pkg::ADC_W-1:0]  rdata
);
  logic [l1f_pkg::ADC_W-1:0] ev_mem [NQ][NCH][WIN];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int c = 0; c < NCH; c++) begin
        ev_mem[wslot][c][wk] <= wdata[c*l1f_pkg::ADC_W +: l1f_pkg::ADC_W];
      end
    end
  end

  assign rdata = ev_mem[rslot][rch][rk];
endmodule

// File: rtl/l1f_formatter.sv
module l1f_formatter #(
  parameter int NCH = 8,
  parameter int WIN = 12,
  localparam int KW = $clog2(WIN),
  localparam int CW = $clog2(NCH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_ready,
  input  logic [l1f_pkg::EVN_W-1:0]   hdr_evn,
  input  logic [l1f_pkg::XING_W-1:0]  hdr_xing,
  input  logic [l1f_pkg::ADC_W-1:0]   rdata,
  output logic [CW-1:0]               rch,
  output logic [KW-1:0]               rk,
  output logic                        slot_release,
  output logic                        out_valid,
  output logic [l1f_pkg::WORD_W-1:0]  out_word
);
  import l1f_pkg::*;

  typedef enum logic [1:0] {F_IDLE, F_DATA, F_TRL} fstate_t;
  fstate_t       st_q;
  logic [CW-1:0] ch_q;
  logic [KW-1:0] k_q;
  logic          last_k, last_ch;

  assign last_k  = (k_q == KW'(WIN - 1));
  assign last_ch = (ch_q == CW'(NCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= F_IDLE;
      ch_q      <= '0;
      k_q       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      case (st_q)
        F_IDLE: begin
          ch_q <= '0;
          k_q  <= '0;
          if (ev_ready) begin
            out_valid <= 1'b1;
            out_word  <= make_hdr(hdr_evn, hdr_xing);
            st_q      <= F_DATA;
          end else begin
            out_valid <= 1'b0;
            out_word  <= '0;
          end
        end
        F_DATA: begin
          out_valid <= 1'b1;
          out_word  <= make_smp(CHF_W'(ch_q), TIX_W'(k_q), rdata);
          if (last_k) begin
            k_q <= '0;
            if (last_ch) st_q <= F_TRL;
            else         ch_q <= ch_q + 1'b1;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        default: begin
          out_valid <= 1'b1;
          out_word  <= make_trl(16'(NCH * WIN));
          st_q      <= F_IDLE;
        end
      endcase
    end
  end

  assign rch          = ch_q;
  assign rk           = k_q;
  assign slot_release = (st_q == F_TRL);

  assert_hdr_then_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_word[31:30] == KIND_HDR) |=> out_valid && (out_word[31:30] == KIND_SMP));
  assert_trl_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_word[31:30] == KIND_TRL) |=> !out_valid || (out_word[31:30] == KIND_HDR));
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == '0));
  assert_sample_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_word[31:30] == KIND_SMP) |=> out_valid);
endmodule

// File: rtl/l1f_event_builder.sv
module l1f_event_builder #(
  parameter int NCH   = 8,
  parameter int WIN   = 12,
  parameter int DEPTH = 64,
  parameter int NQ    = 4,
  parameter int XDIV  = 6,
  parameter int OVF_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int KW     = $clog2(WIN),
  localparam int CW     = $clog2(NCH),
  localparam int SLOT_W = $clog2(NQ),
  localparam int DW     = NCH * l1f_pkg::ADC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DW-1:0]               adc_samples,
  input  logic                        l1_accept,
  input  logic [AW-1:0]               latency_cfg,
  output logic                        out_valid,
  output logic [l1f_pkg::WORD_W-1:0]  out_word,
  output logic                        queue_full,
  output logic [OVF_W-1:0]            overflow_count
);
  logic [AW-1:0]              wr_ptr, ring_rd_addr;
  logic [DW-1:0]              ring_rd_data;
  logic                       cap_we, ev_ready, slot_release;
  logic [SLOT_W-1:0]          cap_slot, rd_slot;
  logic [KW-1:0]              cap_k, rk;
  logic [CW-1:0]              rch;
  logic [l1f_pkg::EVN_W-1:0]  hdr_evn;
  logic [l1f_pkg::XING_W-1:0] hdr_xing;
  logic [l1f_pkg::ADC_W-1:0]  store_rdata;

  l1f_delay_ring #(.NCH(NCH), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_data(adc_samples), .rd_addr(ring_rd_addr),
    .wr_ptr(wr_ptr), .rd_data(ring_rd_data));

  l1f_capture_ctrl #(.NCH(NCH), .WIN(WIN), .DEPTH(DEPTH), .NQ(NQ), .XDIV(XDIV),
                     .OVF_W(OVF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept), .latency_cfg(latency_cfg),
    .wr_ptr(wr_ptr), .slot_release(slot_release), .cap_we(cap_we),
    .cap_slot(cap_slot), .cap_k(cap_k), .ring_rd_addr(ring_rd_addr),
    .rd_slot(rd_slot), .ev_ready(ev_ready), .hdr_evn(hdr_evn),
    .hdr_xing(hdr_xing), .queue_full(queue_full), .overflow_count(overflow_count));

  l1f_event_store #(.NCH(NCH), .WIN(WIN), .NQ(NQ)) u_store (
    .clk(clk), .we(cap_we), .wslot(cap_slot), .wk(cap_k), .wdata(ring_rd_data),
    .rslot(rd_slot), .rch(rch), .rk(rk), .rdata(store_rdata));

  l1f_formatter #(.NCH(NCH), .WIN(WIN)) u_fmt (
    .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .hdr_evn(hdr_evn),
    .hdr_xing(hdr_xing), .rdata(store_rdata), .rch(rch), .rk(rk),
    .slot_release(slot_release), .out_valid(out_valid), .out_word(out_word));

  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full && !slot_release |=> queue_full);
endmodule

// File: tb/l1f_event_builder_tb.sv
`timescale 1ns/1ps
module l1f_event_builder_tb;
  localparam int NCH = 8, WIN = 12, DEPTH = 64, NQ = 4;
  localparam int MAXLAT = DEPTH - WIN - 1;
  localparam int EVW = NCH * WIN + 2;

  logic clk = 0, rst_n = 0, l1_accept = 0;
  logic [NCH*12-1:0] adc_samples;
  logic [5:0] latency_cfg = '0;
  logic out_valid, queue_full;
  logic [31:0] out_word;
  logic [7:0] overflow_count;

  int errors = 0, checks = 0, drv_idx = 0, ecount = 0, cap_n = 0;
  int exp_evn = 0, exp_ovf = 0;
  bit finished = 0;
  logic [31:0] cap_w [1024];
  int cap_at [1024];

  l1f_event_builder u_dut (.clk(clk), .rst_n(rst_n), .adc_samples(adc_samples),
    .l1_accept(l1_accept), .latency_cfg(latency_cfg), .out_valid(out_valid),
    .out_word(out_word), .queue_full(queue_full), .overflow_count(overflow_count));

  always #2 clk = ~clk;

  function automatic logic [11:0] pat(int c, int m);
    return 12'((c << 8) + m * 3);
  endfunction

  always_comb for (int c = 0; c < NCH; c++) adc_samples[c*12 +: 12] = pat(c, drv_idx);

  always @(negedge clk) drv_idx <= drv_idx + 1;
  always @(posedge clk) if (rst_n) ecount <= ecount + 1;
  always @(negedge clk) if (rst_n && out_valid && cap_n < 1024) begin
    cap_w[cap_n] = out_word; cap_at[cap_n] = ecount; cap_n++;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic trig(output int m, output int e);
    @(negedge clk); #1; l1_accept = 1; m = drv_idx; e = ecount;
    @(negedge clk); #1; l1_accept = 0;
  endtask

  task automatic check_event(int base, int evn, int e, int m, int lat);
    logic [31:0] hexp, sexp, bad_a, bad_e;
    int nbad = 0;
    chk(cap_w[base][31:30] == 2'b01, "R5", "header kind", cap_w[base][31:30], 1);
    hexp = {2'b01, 10'b0, 12'(evn), 8'(e / 6)};
    chk(cap_w[base] == hexp, "R6", "header evn/xing", cap_w[base], hexp);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < WIN; k++) begin
        sexp = {2'b00, 8'b0, 6'(c), 4'(k), pat(c, m - lat - WIN + k)};
        if (cap_w[base + 1 + c*WIN + k] !== sexp) begin
          if (nbad == 0) begin bad_a = cap_w[base + 1 + c*WIN + k]; bad_e = sexp; end
          nbad++;
        end
      end
    chk(nbad == 0, "R2", "window samples (first mismatch)", nbad ? bad_a : 0, nbad ? bad_e : 0);
    chk(cap_w[base + EVW - 1] == {2'b11, 14'b0, 16'(NCH*WIN)}, "R5", "trailer",
        cap_w[base + EVW - 1], {2'b11, 14'b0, 16'(NCH*WIN)});
    chk(cap_at[base + EVW - 1] == cap_at[base] + EVW - 1, "R4", "contiguous words",
        cap_at[base + EVW - 1] - cap_at[base], EVW - 1);
  endtask

  task automatic t_reset;
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(out_word == 0, "R1", "out_word", out_word, 0);
    chk(queue_full == 0, "R1", "queue_full", queue_full, 0);
    chk(overflow_count == 0, "R1", "overflow_count", overflow_count, 0);
  endtask

  task automatic t_single(int cfg);
    int m, e, lat;
    lat = (cfg > MAXLAT) ? MAXLAT : cfg;
    latency_cfg = 6'(cfg);
    repeat (4) @(negedge clk);
    cap_n = 0;
    trig(m, e);
    repeat (EVW + 20) @(negedge clk);
    chk(cap_n == EVW, "R4", "word count", cap_n, EVW);
    chk(cap_at[0] == e + WIN + 2, "R7", "header timing", cap_at[0], e + WIN + 2);
    check_event(0, exp_evn, e, m, lat);
    if (cfg > MAXLAT) chk(1, "R3", "clamped latency exercised", 0, 0);
    chk(out_valid == 0 && out_word == 0, "R4", "idle word zero", out_word, 0);
    exp_evn++;
  endtask

  task automatic t_fill;
    int m[5], e[5];
    latency_cfg = 6'd10;
    cap_n = 0;
    for (int i = 0; i < 5; i++) begin
      trig(m[i], e[i]);
      if (i == 3) chk(queue_full == 1, "R8", "queue_full after 4 accepts", queue_full, 1);
      if (i < 4) repeat (11) @(negedge clk);
    end
    exp_ovf++;
    chk(overflow_count == 8'(exp_ovf), "R8", "drop when full", overflow_count, exp_ovf);
    repeat (4 * EVW + 40) @(negedge clk);
    chk(cap_n == 4 * EVW, "R11", "four events out", cap_n, 4 * EVW);
    for (int i = 0; i < 4; i++) check_event(i * EVW, exp_evn + i, e[i], m[i], 10);
    exp_evn += 4;
    chk(queue_full == 0, "R8", "queue drained", queue_full, 0);
  endtask

  task automatic t_busy;
    int m0, e0, m1, e1;
    cap_n = 0;
    trig(m0, e0);
    repeat (3) @(negedge clk);
    trig(m1, e1);
    exp_ovf++;
    chk(overflow_count == 8'(exp_ovf), "R9", "busy drop counted", overflow_count, exp_ovf);
    repeat (EVW + 30) @(negedge clk);
    chk(cap_n == EVW, "R9", "only one event", cap_n, EVW);
    check_event(0, exp_evn, e0, m0, 10);
    exp_evn++;
  endtask

  task automatic t_saturate;
    int m, e;
    @(negedge clk); #1; l1_accept = 1;
    repeat (400) @(negedge clk);
    #1; l1_accept = 0;
    chk(overflow_count == 8'hFF, "R10", "saturated count", overflow_count, 255);
    repeat (700) @(negedge clk);
    chk(out_valid == 0 && queue_full == 0, "R10", "drained after burst", queue_full, 0);
    trig(m, e);
    repeat (2) @(negedge clk);
    trig(m, e);
    chk(overflow_count == 8'hFF, "R10", "holds at 255", overflow_count, 255);
    repeat (EVW + 30) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (DEPTH + 20) @(negedge clk);
    t_single(0);
    t_single(20);
    t_single(MAXLAT);
    t_single(63);
    t_fill();
    t_busy();
    t_saturate();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule